// File: doc/BRIEF.md
# Saturating Up/Down Wiper Position Controller

This block is the digital half of a 32-position stepped resistor selector. Two asynchronous control lines arrive from outside the chip: an active-low select and one line that serves as both the direction choice and the step clock. The block samples both with the system clock, keeps a wiper position and drives a one-hot tap-select bus. Each bit of that bus closes one switch of an external resistor ladder. A higher tap number puts the wiper nearer the high terminal and raises the selected resistance.

Movement happens only inside a select window. The level of the step line at the moment select goes low fixes the direction for the whole window: high means up and low means down. Each later rising edge of the step line moves the wiper by one position. The position stops at the top tap or at tap zero and never wraps. When select goes high again the position is held and a standby flag is raised. The held position is lost only on reset.

Top module: `wiper_ctrl`

## Requirements
- R1: After reset, `position` equals the INIT_POS parameter (default 0), `tap_sel` has only bit INIT_POS set, and `standby` is 1 while `sel_n` is high.
- R2: `tap_sel` always has exactly one bit set, and that bit's index equals `position`. Bit 0 is the low terminal and bit TAPS-1 is the high terminal.
- R3: When `sel_n` goes from 1 to 0, the direction is latched from `updn`: a 1 selects up (increment) and a 0 selects down (decrement).
- R4: While `sel_n` is 0, each 0-to-1 transition of `updn` moves `position` by exactly one step in the latched direction, no more than 5 clock cycles after the input edge. A 1-to-0 transition of `updn` does not move it.
- R5: Moving up saturates at TAPS-1 (31 by default). Further up steps leave `position` at TAPS-1.
- R6: Moving down saturates at 0. Further down steps leave `position` at 0.
- R7: While `sel_n` is 1, transitions of `updn` do not change `position` or `tap_sel`. When select goes high, the position reached is held.
- R8: `standby` is 1 while the synchronized `sel_n` is high and 0 while it is low, no more than 4 cycles after a `sel_n` change.
- R9: A rising `updn` edge that is sampled in the same cycle as the falling `sel_n` edge does not move the wiper. It still sets the direction to up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Asynchronous active-low select |
| updn | input | 1 | Asynchronous direction level / step clock |
| tap_sel | output | TAPS | Registered one-hot tap-select bus |
| position | output | $clog2(TAPS) | Registered wiper position |
| standby | output | 1 | Registered standby flag, 1 while deselected |

## Verification
The falling edge of select and a rising edge of the step line can be sampled in the same clock cycle. When that happens, the direction is latched and no step is taken. The bench provokes this by moving both input pins together on the same falling clock edge while the step line is low. It then checks that the position is unchanged. It next applies a single further step and checks that the position rose by one, which confirms that the direction latched was up.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} wiper_dir_e;
endpackage

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int STAGES = 2,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/wiper_counter.sv
module wiper_counter
  import wiper_pkg::*;
#(
  parameter int TAPS     = 32,
  parameter int INIT_POS = 0,
  localparam int POS_W   = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_fall,
  input  logic             step_rise,
  input  logic             selected,
  input  logic             dir_level,
  output logic [POS_W-1:0] pos,
  output logic [POS_W-1:0] pos_next
);
  localparam logic [POS_W-1:0] TOP  = POS_W'(TAPS - 1);
  localparam logic [POS_W-1:0] INIT = POS_W'(INIT_POS);

  wiper_dir_e dir_q;

  always_comb begin
    pos_next = pos;
    if (selected && step_rise && !sel_fall) begin
      if (dir_q == DIR_UP) begin
        if (pos != TOP) pos_next = pos + 1'b1;
      end else begin
        if (pos != '0) pos_next = pos - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos   <= INIT;
      dir_q <= DIR_UP;
    end else begin
      pos <= pos_next;
      if (sel_fall) dir_q <= wiper_dir_e'(dir_level);
    end
  end
endmodule

// File: rtl/wiper_decode.sv
module wiper_decode #(
  parameter int TAPS   = 32,
  localparam int POS_W = $clog2(TAPS)
) (
  input  logic [POS_W-1:0] pos,
  output logic [TAPS-1:0]  onehot
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign onehot[i] = (pos == POS_W'(i));
  end
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl #(
  parameter int TAPS        = 32,
  parameter int INIT_POS    = 0,
  parameter int SYNC_STAGES = 2,
  localparam int POS_W      = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_n,
  input  logic             updn,
  output logic [TAPS-1:0]  tap_sel,
  output logic [POS_W-1:0] position,
  output logic             standby
);
  logic sel_s, updn_s, sel_q, updn_q;
  logic sel_fall, step_rise;
  logic [POS_W-1:0] pos_next;
  logic [TAPS-1:0]  tap_next;

  wiper_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sel (
    .clk(clk), .rst(rst), .din(sel_n), .dout(sel_s));
  wiper_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_updn (
    .clk(clk), .rst(rst), .din(updn), .dout(updn_s));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= 1'b1;
      updn_q  <= 1'b0;
      standby <= 1'b1;
    end else begin
      sel_q   <= sel_s;
      updn_q  <= updn_s;
      standby <= sel_s;
    end
  end

  assign sel_fall  = sel_q & ~sel_s;
  assign step_rise = ~updn_q & updn_s;

  wiper_counter #(.TAPS(TAPS), .INIT_POS(INIT_POS)) u_count (
    .clk(clk), .rst(rst), .sel_fall(sel_fall), .step_rise(step_rise),
    .selected(~sel_s), .dir_level(updn_s), .pos(position), .pos_next(pos_next));

  wiper_decode #(.TAPS(TAPS)) u_dec (.pos(pos_next), .onehot(tap_next));

  always_ff @(posedge clk) begin
    if (rst) tap_sel <= TAPS'(1) << INIT_POS;
    else     tap_sel <= tap_next;
  end
endmodule

// File: rtl/wiper_ctrl_chk.sv
module wiper_ctrl_chk #(
  parameter int TAPS   = 32,
  localparam int POS_W = $clog2(TAPS)
) (
  input logic             clk,
  input logic             rst,
  input logic [TAPS-1:0]  tap_sel,
  input logic [POS_W-1:0] position,
  input logic             standby,
  input logic             sel_fall
);
  assert_onehot_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(tap_sel) == 1);

  assert_tap_matches_R2: assert property (@(posedge clk) disable iff (rst)
    tap_sel[position]);

  // R4 R5 R6: any movement is a single step, never a wrap
  assert_single_step_R4: assert property (@(posedge clk) disable iff (rst)
    (position != $past(position)) |->
      (position == POS_W'($past(position) + 1'b1) && $past(position) != POS_W'(TAPS-1)) ||
      (position == POS_W'($past(position) - 1'b1) && $past(position) != '0));

  assert_hold_in_standby_R7: assert property (@(posedge clk) disable iff (rst)
    standby |-> $stable(position));

  assert_no_step_on_select_R9: assert property (@(posedge clk) disable iff (rst)
    sel_fall |=> $stable(position));
endmodule

bind wiper_ctrl wiper_ctrl_chk #(.TAPS(TAPS)) u_chk (
  .clk(clk), .rst(rst), .tap_sel(tap_sel), .position(position),
  .standby(standby), .sel_fall(sel_fall));

// File: tb/wiper_ctrl_test.sv
module wiper_ctrl_test;
  localparam int TAPS  = 32;
  localparam int POS_W = $clog2(TAPS);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel_n = 1'b1;
  logic updn = 1'b0;
  logic [TAPS-1:0]  tap_sel;
  logic [POS_W-1:0] position;
  logic             standby;

  int checks = 0;
  int errors = 0;
  int model = 0;

  always #4 clk = ~clk;

  wiper_ctrl #(.TAPS(TAPS)) uut (
    .clk(clk), .rst(rst), .sel_n(sel_n), .updn(updn),
    .tap_sel(tap_sel), .position(position), .standby(standby));

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_state(input string req, input int exp_pos, input bit exp_sb);
    logic [TAPS-1:0] exp_tap;
    exp_tap = TAPS'(1) << exp_pos;
    checks++;
    if (int'(position) != exp_pos || tap_sel != exp_tap || standby != exp_sb) begin
      errors++;
      $display("FAIL %s: pos=%0d tap=%h sb=%0b expected pos=%0d tap=%h sb=%0b",
               req, position, tap_sel, standby, exp_pos, exp_tap, exp_sb);
    end
  endtask

  task automatic step(input bit up, input string req);
    updn = 1'b0; wait_cyc(5);
    updn = 1'b1; wait_cyc(5);
    if (up) model = (model < TAPS-1) ? model + 1 : TAPS-1;
    else    model = (model > 0) ? model - 1 : 0;
    check_state(req, model, 1'b0);
  endtask

  initial begin
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(5);
    check_state("R1", 0, 1'b1);

    // R3: select with updn high latches up
    updn = 1'b1; wait_cyc(5);
    sel_n = 1'b0; wait_cyc(5);
    check_state("R8", 0, 1'b0);
    for (int k = 0; k < TAPS + 6; k++)
      step(1'b1, (model == TAPS-1) ? "R5" : "R4");
    // R4: a falling updn edge alone does not move
    updn = 1'b0; wait_cyc(5);
    check_state("R4", model, 1'b0);

    // R7/R8: deselect, toggles ignored
    sel_n = 1'b1; wait_cyc(5);
    check_state("R8", model, 1'b1);
    for (int k = 0; k < 4; k++) begin
      updn = 1'b1; wait_cyc(5);
      updn = 1'b0; wait_cyc(5);
      check_state("R7", model, 1'b1);
    end

    // R3: select with updn low latches down
    sel_n = 1'b0; wait_cyc(5);
    check_state("R3", model, 1'b0);
    for (int k = 0; k < TAPS + 6; k++)
      step(1'b0, (model == 0) ? "R6" : "R3");

    // partial walk up, hold across a select window
    sel_n = 1'b1; updn = 1'b1; wait_cyc(5);
    sel_n = 1'b0; wait_cyc(5);
    for (int k = 0; k < 7; k++) step(1'b1, "R2");
    sel_n = 1'b1; wait_cyc(5);
    check_state("R7", model, 1'b1);

    // R9: select fall and updn rise together
    updn = 1'b0; wait_cyc(5);
    sel_n = 1'b0; updn = 1'b1; wait_cyc(6);
    check_state("R9", model, 1'b0);
    step(1'b1, "R9");

    // R1: reset returns to initial position
    sel_n = 1'b1; wait_cyc(5);
    rst = 1'b1; wait_cyc(2);
    rst = 1'b0; model = 0; wait_cyc(5);
    check_state("R1", 0, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not end, actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule